// File: doc/BRIEF.md
# Snoop-Aware Eviction Write-Back Buffer

This block sits between a private write-back cache and a shared snooping bus. When the cache has to make room for a miss, it pushes the dirty victim line here instead of waiting for memory. The cache can then request the incoming line at once while the buffer writes victims to memory in the background, oldest first and one at a time.

Each slot carries its own line-address tag, independent of the cache tag arrays. Every transaction that another agent places on the bus is compared against these tags in parallel with the cache's own snoop lookup. A matching read receives the buffered line in the same cycle. A matching read-for-ownership also receives the data, and it removes the entry so that memory never receives a line that another processor now owns in newer form. A second victim for a line that is already buffered overwrites the older copy instead of taking a new slot.

Top module: `wbb_top`

## Requirements
- R1: After reset, no slot is occupied: `ev_ready` is 1, `mem_req` is 0 and `snp_hit` is 0.
- R2: A victim is accepted on a cycle with `ev_valid` and `ev_ready` both high, and its tag and data are stored. Up to DEPTH (default 4) distinct lines are held.
- R3: `ev_ready` is 0 exactly when all DEPTH slots are occupied. A victim offered while `ev_ready` is 0 is not stored.
- R4: `mem_req` is 1 whenever any slot is occupied. `mem_tag`/`mem_data` show the oldest occupied entry, where age is the order of acceptance. An entry leaves the buffer on a cycle where `mem_req` and `mem_gnt` are both 1.
- R5: An ungranted request keeps the same tag on the next cycle unless a read-for-ownership snoop cancels that entry in the current cycle.
- R6: `snp_op` encoding: 2'b00 none, 2'b01 read, 2'b10 read-for-ownership, 2'b11 treated as none. A read snoop whose `snp_tag` matches an entry raises `snp_hit` and drives that entry's data on `snp_data` in the same cycle. The entry stays buffered.
- R7: A read-for-ownership snoop that matches an entry raises `snp_hit` with the data in the same cycle. That entry is then removed and never written to memory. If it was the one being requested, the request is withdrawn.
- R8: If a read-for-ownership snoop matches the entry that memory accepts in the same cycle, that write counts as done and the entry leaves the buffer.
- R9: An accepted victim whose tag matches a stored entry replaces that entry's data and keeps its place in the drain order. No second slot is taken.
- R10: If the victim's tag matches an entry that leaves in the same cycle (granted or cancelled), the new data stays buffered as the youngest entry.
- R11: A snoop compares only against entries stored before its cycle. A victim accepted in the same cycle is not visible to it.
- R12: A snoop with op none or reserved, or with no matching tag, gives `snp_hit` = 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Victim line offered by the cache |
| ev_ready | output | 1 | Buffer can take a victim |
| ev_tag | input | TAG_W | Line address of the victim |
| ev_data | input | DATA_W | Victim line payload |
| snp_valid | input | 1 | Bus snoop present this cycle |
| snp_op | input | 2 | Snoop kind (see R6) |
| snp_tag | input | TAG_W | Line address of the snoop |
| snp_hit | output | 1 | Snoop matched a buffered line |
| snp_data | output | DATA_W | Payload of the matched line |
| mem_req | output | 1 | Write to memory requested |
| mem_gnt | input | 1 | Memory accepts the write this cycle |
| mem_tag | output | TAG_W | Line address of the write |
| mem_data | output | DATA_W | Payload of the write |

## Verification
The interesting collision is a read-for-ownership snoop that lands on the head entry in the very cycle memory grants that entry's write. A related collision is a victim that merges into the head while that head is being granted. Both are provoked on purpose in directed steps and then reached many more times by a random phase over an eight-tag address space with random grants. A behavioural queue model decides each outcome: a granted write is logged and its entry removed before any cancel applies, and a merge into a departing entry reappears at the tail. Every output is compared against the model on every cycle.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  typedef enum logic [1:0] {
    SNP_NONE = 2'b00,
    SNP_READ = 2'b01,
    SNP_RFO  = 2'b10,
    SNP_RSVD = 2'b11
  } snp_op_e;
endpackage

// File: rtl/wbb_rst_sync.sv
module wbb_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/wbb_tag_cmp.sv
module wbb_tag_cmp #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 26
) (
  input  logic [DEPTH-1:0]            vld,
  input  logic [DEPTH-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]            key,
  output logic [DEPTH-1:0]            hit
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = vld[i] && (tags[i] == key);
  end
endmodule

// File: rtl/wbb_age.sv
module wbb_age #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] alloc,
  output logic [DEPTH-1:0] oldest
);
  // older_q[a][b] set: slot a was filled before slot b
  logic [DEPTH-1:0][DEPTH-1:0] older_q, older_d;

  always_comb begin
    older_d = older_q;
    for (int k = 0; k < DEPTH; k++) begin
      if (alloc[k]) begin
        for (int j = 0; j < DEPTH; j++) older_d[k][j] = 1'b0;
        for (int j = 0; j < DEPTH; j++) if (j != k) older_d[j][k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) older_q <= '0;
    else        older_q <= older_d;
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < DEPTH; j++) blocked = blocked | (vld[j] & older_q[j][i]);
      oldest[i] = vld[i] & ~blocked;
    end
  end

  assert_oldest_unique_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|vld) |-> $onehot(oldest));
endmodule

// File: rtl/wbb_top.sv
module wbb_top #(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 26,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [TAG_W-1:0]  ev_tag,
  input  logic [DATA_W-1:0] ev_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_op,
  input  logic [TAG_W-1:0]  snp_tag,
  output logic              snp_hit,
  output logic [DATA_W-1:0] snp_data,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic [TAG_W-1:0]  mem_tag,
  output logic [DATA_W-1:0] mem_data
);
  import wbb_pkg::*;

  logic                             rst_sn;
  logic [DEPTH-1:0]                 vld_q, vld_d;
  logic [DEPTH-1:0][TAG_W-1:0]      tag_q;
  logic [DEPTH-1:0][DATA_W-1:0]     dat_q;
  logic [DEPTH-1:0]                 snp_match, ev_match, oldest;
  logic [DEPTH-1:0]                 free_oh, rfo_kill, drain_kill, leaving;
  logic [DEPTH-1:0]                 wr_oh, alloc_oh;
  snp_op_e                          op;
  logic                             snp_act, ev_fire;

  wbb_rst_sync u_rst (.clk(clk), .rst_ni(rst_n), .rst_no(rst_sn));

  wbb_tag_cmp #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_snp_cmp (
    .vld(vld_q), .tags(tag_q), .key(snp_tag), .hit(snp_match));

  wbb_tag_cmp #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ev_cmp (
    .vld(vld_q), .tags(tag_q), .key(ev_tag), .hit(ev_match));

  wbb_age #(.DEPTH(DEPTH)) u_age (
    .clk(clk), .rst_n(rst_sn), .vld(vld_q), .alloc(alloc_oh), .oldest(oldest));

  // snoop side
  assign op      = snp_op_e'(snp_op);
  assign snp_act = snp_valid && (op == SNP_READ || op == SNP_RFO);
  assign snp_hit = snp_act && (|snp_match);
  assign rfo_kill = (snp_valid && op == SNP_RFO) ? snp_match : '0;

  always_comb begin
    snp_data = '0;
    mem_tag  = '0;
    mem_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (snp_match[i]) snp_data = snp_data | dat_q[i];
      if (oldest[i]) begin
        mem_tag  = mem_tag  | tag_q[i];
        mem_data = mem_data | dat_q[i];
      end
    end
  end

  // drain side
  assign mem_req    = |vld_q;
  assign drain_kill = (mem_req && mem_gnt) ? oldest : '0;
  assign leaving    = drain_kill | rfo_kill;

  // eviction side
  assign ev_ready = ~(&vld_q);
  assign ev_fire  = ev_valid && ev_ready;

  always_comb begin
    logic found;
    found   = 1'b0;
    free_oh = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !found) begin
        free_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    wr_oh = '0;
    if (ev_fire) wr_oh = (|ev_match) ? ev_match : free_oh;
    alloc_oh = wr_oh & (~vld_q | leaving);
    vld_d    = (vld_q & ~leaving) | wr_oh;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) vld_q <= '0;
    else         vld_q <= vld_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_oh[i]) begin
        tag_q[i] <= ev_tag;
        dat_q[i] <= ev_data;
      end
    end
  end

  // request held until granted or cancelled
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req && !mem_gnt && !(snp_valid && op == SNP_RFO && snp_tag == mem_tag))
    |=> (mem_req && $stable(mem_tag)));

  // cancelled line never reaches memory afterwards
  assert_rfo_drop_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (snp_valid && op == SNP_RFO && snp_hit
     && !(ev_valid && ev_ready && ev_tag == snp_tag))
    |=> !(mem_req && mem_tag == $past(snp_tag)));

  // full buffer refuses new lines
  assert_full_refuse_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (ev_valid && !ev_ready && !mem_gnt && !(snp_valid && op == SNP_RFO))
    |=> $stable(vld_q));

  // merging keeps tags unique
  for (genvar a = 0; a < DEPTH; a++) begin : g_dup_a
    for (genvar b = a + 1; b < DEPTH; b++) begin : g_dup_b
      assert_no_dup_tag_R9: assert property (@(posedge clk) disable iff (!rst_sn)
        (vld_q[a] && vld_q[b]) |-> (tag_q[a] != tag_q[b]));
    end
  end
endmodule

// File: tb/wbb_top_tb.sv
module wbb_top_tb;
  localparam int DEPTH  = 4;
  localparam int TAG_W  = 26;
  localparam int DATA_W = 64;

  typedef struct {
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } ent_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ev_valid, ev_ready;
  logic [TAG_W-1:0]  ev_tag;
  logic [DATA_W-1:0] ev_data;
  logic              snp_valid, snp_hit;
  logic [1:0]        snp_op;
  logic [TAG_W-1:0]  snp_tag;
  logic [DATA_W-1:0] snp_data;
  logic              mem_req, mem_gnt;
  logic [TAG_W-1:0]  mem_tag;
  logic [DATA_W-1:0] mem_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  ent_t model[$];
  int wr_cnt[int];

  always #10 clk = ~clk;

  wbb_top #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_tag(ev_tag), .ev_data(ev_data),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_tag(snp_tag),
    .snp_hit(snp_hit), .snp_data(snp_data),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_tag(mem_tag), .mem_data(mem_data));

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int find(input ent_t q[$], input logic [TAG_W-1:0] t);
    for (int i = 0; i < q.size(); i++) if (q[i].tag == t) return i;
    return -1;
  endfunction

  // drive one cycle, compare outputs against the queue model, advance model
  task automatic step(input bit ev_v, input logic [TAG_W-1:0] ev_t,
                      input logic [DATA_W-1:0] ev_d, input bit sv,
                      input logic [1:0] sop, input logic [TAG_W-1:0] st,
                      input bit g, input string req);
    ent_t pre[$];
    int   hi;
    bit   e_ready, e_hit, rfo, fire;
    @(negedge clk);
    ev_valid = ev_v; ev_tag = ev_t; ev_data = ev_d;
    snp_valid = sv; snp_op = sop; snp_tag = st; mem_gnt = g;
    #5;
    pre     = model;
    e_ready = (pre.size() < DEPTH);
    hi      = find(pre, st);
    e_hit   = sv && (sop == 2'b01 || sop == 2'b10) && (hi >= 0);
    rfo     = sv && (sop == 2'b10);
    chk({req, "/R3"}, "ev_ready", 64'(ev_ready), 64'(e_ready));
    chk({req, "/R4"}, "mem_req", 64'(mem_req), 64'(pre.size() > 0));
    if (pre.size() > 0) begin
      chk({req, "/R4"}, "mem_tag", 64'(mem_tag), 64'(pre[0].tag));
      chk({req, "/R4"}, "mem_data", mem_data, pre[0].data);
    end
    chk({req, "/R6"}, "snp_hit", 64'(snp_hit), 64'(e_hit));
    if (e_hit) chk({req, "/R6"}, "snp_data", snp_data, pre[hi].data);
    // advance model: grant first, then cancel, then victim
    fire = ev_v && e_ready;
    if (g && model.size() > 0) begin
      int k = int'(model[0].tag);
      if (wr_cnt.exists(k)) wr_cnt[k]++; else wr_cnt[k] = 1;
      void'(model.pop_front());
    end
    if (rfo) begin
      int r = find(model, st);
      if (r >= 0) model.delete(r);
    end
    if (fire) begin
      int m = find(model, ev_t);
      ent_t n;
      n.tag = ev_t; n.data = ev_d;
      if (m >= 0) model[m].data = ev_d;
      else model.push_back(n);
    end
  endtask

  task automatic idle(input bit g, input string req);
    step(1'b0, '0, '0, 1'b0, 2'b00, '0, g, req);
  endtask

  function automatic int wcount(input logic [TAG_W-1:0] t);
    return wr_cnt.exists(int'(t)) ? wr_cnt[int'(t)] : 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ev_valid = 0; ev_tag = '0; ev_data = '0;
    snp_valid = 0; snp_op = 2'b00; snp_tag = '0; mem_gnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #5;
    chk("R1", "ev_ready", 64'(ev_ready), 64'd1);
    chk("R1", "mem_req", 64'(mem_req), 64'd0);
    chk("R1", "snp_hit", 64'(snp_hit), 64'd0);

    // fill all slots
    step(1, 26'h10, 64'hA0A0, 0, 2'b00, '0, 0, "R2");
    step(1, 26'h11, 64'hB1B1, 0, 2'b00, '0, 0, "R2");
    step(1, 26'h12, 64'hC2C2, 0, 2'b00, '0, 0, "R2");
    step(1, 26'h13, 64'hD3D3, 0, 2'b00, '0, 0, "R2");
    // full: offered victim refused
    step(1, 26'h14, 64'hE4E4, 0, 2'b00, '0, 0, "R3");
    idle(0, "R5");
    // read snoop hits, entry kept
    step(0, '0, '0, 1, 2'b01, 26'h12, 0, "R6");
    // reserved op, and unmatched tag
    step(0, '0, '0, 1, 2'b11, 26'h12, 0, "R12");
    step(0, '0, '0, 1, 2'b01, 26'h99, 0, "R12");
    step(0, '0, '0, 0, 2'b10, 26'h10, 0, "R12");
    // cancel the head while ungranted
    step(0, '0, '0, 1, 2'b10, 26'h10, 0, "R7");
    idle(0, "R7");
    // merge into a stored line
    step(1, 26'h12, 64'hC2C3, 0, 2'b00, '0, 0, "R9");
    idle(0, "R9");
    // grant head (0x11)
    idle(1, "R4");
    // head is 0x12: cancel and grant together
    step(0, '0, '0, 1, 2'b10, 26'h12, 1, "R8");
    chk("R8", "writes of 0x12", 64'(wcount(26'h12)), 64'd1);
    // only 0x13 left; add 0x14, then merge into head while granted
    step(1, 26'h14, 64'hE4E4, 0, 2'b00, '0, 0, "R2");
    step(1, 26'h13, 64'hD3D4, 0, 2'b00, '0, 1, "R10");
    idle(0, "R10");
    // snoop does not see same-cycle victim
    step(1, 26'h15, 64'hF5F5, 1, 2'b01, 26'h15, 0, "R11");
    step(0, '0, '0, 1, 2'b01, 26'h15, 0, "R11");
    // drain everything
    repeat (6) idle(1, "R4");
    chk("R7", "writes of cancelled 0x10", 64'(wcount(26'h10)), 64'd0);
    chk("R10", "writes of 0x13", 64'(wcount(26'h13)), 64'd2);
    chk("R4", "buffer empty", 64'(mem_req), 64'd0);

    // random collisions over a small tag space
    for (int n = 0; n < 4000; n++) begin
      logic [TAG_W-1:0] et, sn;
      logic [1:0] op;
      et = TAG_W'($urandom_range(0, 7));
      sn = TAG_W'($urandom_range(0, 7));
      op = 2'($urandom_range(0, 3));
      step(($urandom_range(0, 2) != 0), et, {$urandom, $urandom},
           ($urandom_range(0, 1) == 1), op, sn, ($urandom_range(0, 2) == 0), "R5");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule